// File: doc/BRIEF.md
# APV Analog Level Discriminator

This block turns a stream of raw 12-bit ADC samples taken from an APV analog output into a stream of two-bit symbols. Each valid sample is sorted into one of four classes: a digital one, a digital zero, an undefined level between the two, or a flatline. A flatline is a level close to half of full scale. It is what the ADC sees when no frontend card is plugged in. The symbols feed the header and synchronisation logic downstream.

The four thresholds live in one 32-bit configuration register that software can write and read back. Each threshold is held as an 8-bit coarse value and widened to 12 bits by appending a zero nibble, so a field value of 0xA0 means an ADC level of 0xA00. A sticky flag reports a missing card once a long, unbroken run of flatline symbols has been seen. The flag stays set until software writes the register again.

Top module: `apv_level_discriminator`

## Requirements
- R1: After reset the register reads 0xA0308878. Bits 31:24 hold the one-minimum field, bits 23:16 the zero-maximum field, bits 15:8 the flat-upper field and bits 7:0 the flat-lower field. After reset sym_valid and card_missing are 0.
- R2: A write with cfg_wr_en high stores cfg_wr_data. From the next cycle cfg_rd_data returns exactly that value, and it does not change while no write occurs.
- R3: Each field is read as a 12-bit level with its 4 low bits set to zero. A sample at or above the one-minimum level gives code 2'b01 (one).
- R4: A sample at or below the zero-maximum level that is not a one gives code 2'b00 (zero).
- R5: A sample that is neither one nor zero and lies within the flat-lower and flat-upper levels, both ends included, gives code 2'b11 (flat). Any other sample gives 2'b10 (undefined).
- R6: The classes are tested in a fixed order of priority: one, then zero, then flat, then undefined. A sample that also lies inside the flat window is still reported as one or zero.
- R7: sym_valid is high exactly one cycle after smp_valid, and sym_code carries that sample's class. A sample presented in the same cycle as a write is judged against the thresholds in force before that write.
- R8: card_missing rises in the same cycle as the 64th consecutive flat symbol. Cycles without a valid sample do not break the run. Any valid non-flat sample restarts the count.
- R9: card_missing stays set until a register write. The cycle after a write it reads 0, and the flat run count starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Threshold register write strobe |
| cfg_wr_data | input | 32 | Threshold register write value |
| cfg_rd_data | output | 32 | Threshold register contents |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 12 | Raw ADC sample |
| sym_valid | output | 1 | Symbol strobe, one cycle after the sample |
| sym_code | output | 2 | Symbol class: 00 zero, 01 one, 10 undefined, 11 flat |
| card_missing | output | 1 | Sticky flag for a long flatline run |

## Verification
A table of samples is run through the block under the power-up thresholds. It places values exactly on each threshold and one LSB on either side of it, which separates inclusive comparisons from exclusive ones and shows that the zero nibble is appended to each field. A second threshold set is loaded to show that the fields are taken from the right bit positions. A third set places the one-minimum level inside the flat window, which exposes the priority order. Flatline runs of 63 and 64 samples are driven, some with idle gaps and some broken by an undefined sample, to pin down when the counter fires and what restarts it. A write made in the same cycle as a sample tells old thresholds from new ones.

// File: rtl/apv_level_discriminator.sv
module apv_level_discriminator #(
  parameter int          SAMPLE_W = 12,
  parameter int          FIELD_W  = 8,
  parameter int          FLAT_RUN = 64,
  parameter logic [31:0] CFG_INIT = 32'hA030_8878
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr_en,
  input  logic [4*FIELD_W-1:0]  cfg_wr_data,
  output logic [4*FIELD_W-1:0]  cfg_rd_data,
  input  logic                  smp_valid,
  input  logic [SAMPLE_W-1:0]   smp_data,
  output logic                  sym_valid,
  output logic [1:0]            sym_code,
  output logic                  card_missing
);

  localparam int SHIFT = SAMPLE_W - FIELD_W;
  localparam int CNT_W = $clog2(FLAT_RUN + 1);
  localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(FLAT_RUN - 1);
  localparam logic [CNT_W-1:0] RUN_MAX  = CNT_W'(FLAT_RUN);

  localparam logic [1:0] SYM_ZERO  = 2'b00;
  localparam logic [1:0] SYM_ONE   = 2'b01;
  localparam logic [1:0] SYM_UNDEF = 2'b10;
  localparam logic [1:0] SYM_FLAT  = 2'b11;

  logic [4*FIELD_W-1:0] cfg_q;
  logic [SAMPLE_W-1:0]  lvl_one, lvl_zero, lvl_flat_hi, lvl_flat_lo;
  logic                 hit_one, hit_zero, hit_flat;
  logic [1:0]           cls;
  logic [CNT_W-1:0]     run_cnt;

  assign lvl_one     = {cfg_q[4*FIELD_W-1:3*FIELD_W], {SHIFT{1'b0}}};
  assign lvl_zero    = {cfg_q[3*FIELD_W-1:2*FIELD_W], {SHIFT{1'b0}}};
  assign lvl_flat_hi = {cfg_q[2*FIELD_W-1:FIELD_W],   {SHIFT{1'b0}}};
  assign lvl_flat_lo = {cfg_q[FIELD_W-1:0],           {SHIFT{1'b0}}};

  assign hit_one  = smp_data >= lvl_one;
  assign hit_zero = smp_data <= lvl_zero;
  assign hit_flat = (smp_data >= lvl_flat_lo) && (smp_data <= lvl_flat_hi);

  always_comb begin
    if (hit_one)       cls = SYM_ONE;
    else if (hit_zero) cls = SYM_ZERO;
    else if (hit_flat) cls = SYM_FLAT;
    else               cls = SYM_UNDEF;
  end

  assign cfg_rd_data = cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         cfg_q <= CFG_INIT[4*FIELD_W-1:0];
    else if (cfg_wr_en) cfg_q <= cfg_wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sym_valid <= 1'b0;
      sym_code  <= SYM_ZERO;
    end else begin
      sym_valid <= smp_valid;
      if (smp_valid) sym_code <= cls;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || cfg_wr_en) begin
      run_cnt      <= '0;
      card_missing <= 1'b0;
    end else if (smp_valid) begin
      if (cls == SYM_FLAT) begin
        if (run_cnt != RUN_MAX)  run_cnt <= run_cnt + 1'b1;
        if (run_cnt == RUN_LAST) card_missing <= 1'b1;
      end else begin
        run_cnt <= '0;
      end
    end
  end

endmodule

// File: rtl/apv_level_discriminator_chk.sv
module apv_level_discriminator_chk #(
  parameter int SAMPLE_W = 12,
  parameter int FIELD_W  = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_wr_en,
  input logic [4*FIELD_W-1:0] cfg_wr_data,
  input logic [4*FIELD_W-1:0] cfg_rd_data,
  input logic                 smp_valid,
  input logic [SAMPLE_W-1:0]  smp_data,
  input logic                 sym_valid,
  input logic [1:0]           sym_code,
  input logic                 card_missing
);
  localparam int SHIFT = SAMPLE_W - FIELD_W;

  logic [SAMPLE_W-1:0] t_one, t_zero, t_hi, t_lo;
  assign t_one  = {cfg_rd_data[4*FIELD_W-1:3*FIELD_W], {SHIFT{1'b0}}};
  assign t_zero = {cfg_rd_data[3*FIELD_W-1:2*FIELD_W], {SHIFT{1'b0}}};
  assign t_hi   = {cfg_rd_data[2*FIELD_W-1:FIELD_W],   {SHIFT{1'b0}}};
  assign t_lo   = {cfg_rd_data[FIELD_W-1:0],           {SHIFT{1'b0}}};

  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> sym_valid);
  assert_no_spurious_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> !sym_valid);
  assert_one_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_code == 2'b01) |-> $past(smp_data) >= $past(t_one));
  assert_zero_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_code == 2'b00) |-> ($past(smp_data) <= $past(t_zero)) && ($past(smp_data) < $past(t_one)));
  assert_flat_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_code == 2'b11) |-> ($past(smp_data) >= $past(t_lo)) && ($past(smp_data) <= $past(t_hi)));
  assert_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_code[1]) |-> ($past(smp_data) < $past(t_one)) && ($past(smp_data) > $past(t_zero)));
  assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> cfg_rd_data == $past(cfg_wr_data));
  assert_reg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr_en |=> $stable(cfg_rd_data));
  assert_flag_on_flat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_missing) |-> sym_valid && sym_code == 2'b11);
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (card_missing && !cfg_wr_en) |=> card_missing);
  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> !card_missing);
endmodule

bind apv_level_discriminator apv_level_discriminator_chk #(
  .SAMPLE_W(SAMPLE_W), .FIELD_W(FIELD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
  .cfg_rd_data(cfg_rd_data), .smp_valid(smp_valid), .smp_data(smp_data),
  .sym_valid(sym_valid), .sym_code(sym_code), .card_missing(card_missing)
);

// File: tb/apv_level_discriminator_tb.sv
module apv_level_discriminator_tb;
  localparam int CLK_P = 10;
  localparam logic [31:0] CFG_DEF = 32'hA030_8878;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] cfg_rd_data;
  logic        smp_valid = 1'b0;
  logic [11:0] smp_data = '0;
  logic        sym_valid;
  logic [1:0]  sym_code;
  logic        card_missing;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  apv_level_discriminator u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .smp_valid(smp_valid), .smp_data(smp_data),
    .sym_valid(sym_valid), .sym_code(sym_code), .card_missing(card_missing)
  );

  // {expected code, sample} under the power-up thresholds
  localparam logic [13:0] VEC [12] = '{
    {2'b00, 12'h000}, {2'b00, 12'h300}, {2'b10, 12'h301}, {2'b10, 12'h77F},
    {2'b11, 12'h780}, {2'b11, 12'h800}, {2'b11, 12'h880}, {2'b10, 12'h881},
    {2'b10, 12'h9FF}, {2'b01, 12'hA00}, {2'b01, 12'hFFF}, {2'b00, 12'h2FF}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [11:0] s);
    @(negedge clk);
    cfg_wr_en = 1'b0;
    smp_valid = v;
    smp_data  = s;
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic cls(input logic [11:0] s, input logic [1:0] exp, input string req);
    step(1'b1, s);
    check(sym_valid && sym_code == exp, req, {sym_valid, sym_code}, {1'b1, exp});
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en   = 1'b1;
    cfg_wr_data = d;
    smp_valid   = 1'b0;
    @(posedge clk);
    #(CLK_P/4);
  endtask

  initial begin
    #(CLK_P*100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    check(cfg_rd_data == CFG_DEF, "R1", cfg_rd_data, CFG_DEF);
    check(!sym_valid && !card_missing, "R1", {sym_valid, card_missing}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    foreach (VEC[i]) cls(VEC[i][11:0], VEC[i][13:12], "R3/R4/R5 table");

    step(1'b0, 12'hA00);
    check(!sym_valid, "R7 idle", sym_valid, 0);

    wr(32'h8040_7060);
    check(cfg_rd_data == 32'h8040_7060, "R2", cfg_rd_data, 32'h8040_7060);
    step(1'b0, 12'h000);
    check(cfg_rd_data == 32'h8040_7060, "R2 hold", cfg_rd_data, 32'h8040_7060);
    cls(12'h800, 2'b01, "R3 new field");
    cls(12'h7FF, 2'b10, "R5 new field");
    cls(12'h400, 2'b00, "R4 new field");
    cls(12'h401, 2'b10, "R4 edge");
    cls(12'h600, 2'b11, "R5 low edge");
    cls(12'h700, 2'b11, "R5 high edge");
    cls(12'h5FF, 2'b10, "R5 below");

    wr(32'h7040_8060);
    cls(12'h780, 2'b01, "R6 one beats flat");
    cls(12'h6FF, 2'b11, "R6 flat below one");
    wr(32'hA070_8060);
    cls(12'h680, 2'b00, "R6 zero beats flat");

    wr(CFG_DEF);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = 32'h8040_7060; smp_valid = 1'b1; smp_data = 12'h900;
    @(posedge clk);
    #(CLK_P/4);
    check(sym_valid && sym_code == 2'b10, "R7 old thresholds", sym_code, 2'b10);
    cls(12'h900, 2'b01, "R7 new thresholds");

    wr(CFG_DEF);
    for (int i = 0; i < 32; i++) step(1'b1, 12'h800);
    step(1'b0, 12'h000);
    for (int i = 0; i < 31; i++) step(1'b1, 12'h800);
    check(!card_missing, "R8 63 flat", card_missing, 0);
    step(1'b1, 12'h800);
    check(card_missing && sym_code == 2'b11, "R8 64th flat", card_missing, 1);

    step(1'b1, 12'h000);
    check(card_missing, "R9 sticky", card_missing, 1);
    wr(CFG_DEF);
    check(!card_missing, "R9 write clears", card_missing, 0);

    for (int i = 0; i < 40; i++) step(1'b1, 12'h7A0);
    step(1'b1, 12'h500);
    for (int i = 0; i < 63; i++) step(1'b1, 12'h7A0);
    check(!card_missing, "R8 run restarted", card_missing, 0);
    step(1'b1, 12'h7A0);
    check(card_missing, "R8 run after restart", card_missing, 1);

    for (int i = 0; i < 30; i++) step(1'b1, 12'h800);
    wr(CFG_DEF);
    for (int i = 0; i < 40; i++) step(1'b1, 12'h800);
    check(!card_missing, "R9 count restarts on write", card_missing, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule